// File: doc/BRIEF.md
# Conditional Battery Backup Controller

This block decides what feeds the backed-up RAM supply rail when the main supply fails. It can switch the rail to the battery, or it can leave the rail floating to save battery life. The choice comes from a backup request input. The block samples that input once, in the cycle the supply drops below the reset threshold. It keeps the sampled value in a one-bit memory. Much later, when the supply reaches the battery switchover point, that stored bit selects one of two power states: battery-fed (`PS_BATT`) or floating (`PS_SAVE`). Changes on the request input after sampling have no effect.

The block also gates the RAM chip enable and drives the low-line status. It asks the power-fail output to go low whenever the rail is not fed from the main supply. All inputs are synchronous flags from external comparators:
- `below_rst`: the supply is under the reset threshold.
- `below_swdn`: the supply is at or below the falling switchover point.
- `above_swup`: the supply is above the rising switchover point.

The falling point sits below the rising point. The gap between the two is the hysteresis band.

The FSM has three states:
- `PS_MAIN`: the rail is fed from the main supply.
- `PS_BATT`: the rail is fed from the battery.
- `PS_SAVE`: both switches are off and the rail floats.

It has four transitions:
- `PS_MAIN`→`PS_BATT` when `below_swdn` is high and the stored bit is 1 (*drop-to-battery*).
- `PS_MAIN`→`PS_SAVE` when `below_swdn` is high and the stored bit is 0 (*drop-to-save*).
- `PS_BATT`→`PS_MAIN` when `above_swup` is high (*battery-recover*).
- `PS_SAVE`→`PS_MAIN` when `above_swup` is high (*save-recover*).

In every other case the FSM holds its state. Out of reset it enters `PS_BATT` if `MEM_INIT` is 1 and `PS_SAVE` if it is 0. The main switch therefore stays off until the rising switchover flag is seen.

Top module: `cbb_ctrl`

## Requirements
- R1: After reset the stored bit equals `MEM_INIT`. The state is `PS_BATT` (`batt_en`=1, `main_en`=0) when `MEM_INIT`=1, and `PS_SAVE` (both enables 0) when `MEM_INIT`=0.
- R2: `bkup_req` is sampled only in the cycle where `below_rst` is 1 and was 0 in the previous cycle. If `below_swdn` also rises in that same cycle, the freshly sampled value is used. Later changes on `bkup_req` do not alter the stored bit.
- R3: In `PS_MAIN` with `below_swdn`=1 and a stored bit of 1, the next clock gives `batt_en`=1, `main_en`=0 and `batt_on`=1.
- R4: In `PS_MAIN` with `below_swdn`=1 and a stored bit of 0, the next clock gives `main_en`=0, `batt_en`=0 and `batt_on`=0.
- R5: In `PS_BATT` or `PS_SAVE`, the block returns to `PS_MAIN` on the clock after `above_swup`=1. While `above_swup`=0 it stays where it is. In `PS_MAIN`, it leaves only when `below_swdn`=1.
- R6: `batt_on` is 0 in `PS_MAIN` and in `PS_SAVE`, and 1 only in `PS_BATT`.
- R7: `ce_out` equals `ce_in` combinationally when `below_rst`=0 and the state is `PS_MAIN`. Otherwise `ce_out` is 1 whatever `ce_in` is.
- R8: `low_line` is 0 when `below_rst`=1 or the state is not `PS_MAIN`. It returns to 1 combinationally as soon as `below_rst`=0 in `PS_MAIN`.
- R9: `pfo_force_low` is 1 exactly when the state is not `PS_MAIN`.
- R10: `main_en` and `batt_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| below_rst | input | 1 | Supply below the reset threshold |
| below_swdn | input | 1 | Supply at or below the falling switchover point |
| above_swup | input | 1 | Supply above the rising switchover point |
| bkup_req | input | 1 | Backup request (1 = keep RAM on battery); a floating pin reads 1 |
| ce_in | input | 1 | RAM chip enable from the address decoder |
| main_en | output | 1 | Main supply switch enable |
| batt_en | output | 1 | Battery switch enable |
| batt_on | output | 1 | High while the rail is fed from the battery |
| ce_out | output | 1 | Gated RAM chip enable |
| low_line | output | 1 | Low when the supply is under threshold or off the main switch |
| pfo_force_low | output | 1 | Forces the power-fail output low |

## Verification
The bench builds two copies of the block.
- Instance `u0` uses the default `MEM_INIT`=1 and runs every scenario.
- Instance `u1` uses `MEM_INIT`=0. Its reset state is checked, which brings the floating power-up state within reach.

The scenarios cover:
- Sampling the request and then flipping it before the switchover.
- Holding the supply inside the hysteresis band.
- Raising the reset and switchover flags in the same cycle.
- Toggling the chip enable on both sides of the reset threshold.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
    typedef enum logic [1:0] {
        PS_MAIN = 2'd0,
        PS_BATT = 2'd1,
        PS_SAVE = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/cbb_capture.sv
module cbb_capture #(
    parameter bit MEM_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_rst,
    input  logic bkup_req,
    output logic mem_now
);
    logic prev_q;
    logic mem_q;
    logic drop_evt;

    // the supply crosses the reset threshold downward in this cycle
    assign drop_evt = below_rst & ~prev_q;
    assign mem_now  = drop_evt ? bkup_req : mem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            mem_q  <= MEM_INIT;
        end else begin
            prev_q <= below_rst;
            if (drop_evt) begin
                mem_q <= bkup_req;
            end
        end
    end

    // R2: away from a threshold crossing, the stored choice persists
    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q || !below_rst) |=> $stable(mem_q) || $rose(below_rst) || $past(below_rst && !prev_q));
endmodule

// File: rtl/cbb_fsm.sv
module cbb_fsm
    import cbb_pkg::*;
#(
    parameter bit MEM_INIT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       below_swdn,
    input  logic       above_swup,
    input  logic       mem_now,
    output pwr_state_t state
);
    localparam pwr_state_t RST_STATE = MEM_INIT ? PS_BATT : PS_SAVE;

    pwr_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RST_STATE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_MAIN: begin
                if (below_swdn) begin
                    state_nx = mem_now ? PS_BATT : PS_SAVE;
                end
            end
            PS_BATT: begin
                if (above_swup) begin
                    state_nx = PS_MAIN;
                end
            end
            PS_SAVE: begin
                if (above_swup) begin
                    state_nx = PS_MAIN;
                end
            end
            default: state_nx = RST_STATE;
        endcase
    end

    assert_drop_batt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_MAIN && below_swdn && mem_now) |=> (state == PS_BATT));
    assert_drop_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_MAIN && below_swdn && !mem_now) |=> (state == PS_SAVE));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_MAIN && !above_swup) |=> $stable(state));
    assert_stay_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_MAIN && !below_swdn) |=> (state == PS_MAIN));
endmodule

// File: rtl/cbb_ctrl.sv
module cbb_ctrl
    import cbb_pkg::*;
#(
    parameter bit MEM_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_rst,
    input  logic below_swdn,
    input  logic above_swup,
    input  logic bkup_req,
    input  logic ce_in,
    output logic main_en,
    output logic batt_en,
    output logic batt_on,
    output logic ce_out,
    output logic low_line,
    output logic pfo_force_low
);
    logic       mem_now;
    pwr_state_t state;
    logic       supply_bad;

    cbb_capture #(.MEM_INIT(MEM_INIT)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_rst (below_rst),
        .bkup_req  (bkup_req),
        .mem_now   (mem_now)
    );

    cbb_fsm #(.MEM_INIT(MEM_INIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .below_swdn (below_swdn),
        .above_swup (above_swup),
        .mem_now    (mem_now),
        .state      (state)
    );

    always_comb begin
        main_en       = 1'b0;
        batt_en       = 1'b0;
        batt_on       = 1'b0;
        pfo_force_low = 1'b1;
        unique case (state)
            PS_MAIN: begin
                main_en       = 1'b1;
                pfo_force_low = 1'b0;
            end
            PS_BATT: begin
                batt_en = 1'b1;
                batt_on = 1'b1;
            end
            PS_SAVE: begin
            end
            default: begin
            end
        endcase
    end

    // write protection and low-line share one condition
    assign supply_bad = below_rst | (state != PS_MAIN);
    assign ce_out     = supply_bad ? 1'b1 : ce_in;
    assign low_line   = ~supply_bad;

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_en, batt_en}));
    assert_pfo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        batt_on |-> (pfo_force_low && !low_line && ce_out));
    assert_batt_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        main_en |-> !batt_on);
endmodule

// File: tb/sim_cbb_ctrl.sv
`timescale 1ns/1ps
module sim_cbb_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_rst = 1'b1, below_swdn = 1'b1, above_swup = 1'b0;
    logic bkup_req = 1'b1, ce_in = 1'b0;
    logic main_en, batt_en, batt_on, ce_out, low_line, pfo_force_low;
    logic m1, b1, o1, c1, l1, p1;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cbb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .below_rst(below_rst), .below_swdn(below_swdn),
        .above_swup(above_swup), .bkup_req(bkup_req), .ce_in(ce_in),
        .main_en(main_en), .batt_en(batt_en), .batt_on(batt_on), .ce_out(ce_out),
        .low_line(low_line), .pfo_force_low(pfo_force_low)
    );

    cbb_ctrl #(.MEM_INIT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .below_rst(below_rst), .below_swdn(below_swdn),
        .above_swup(above_swup), .bkup_req(bkup_req), .ce_in(ce_in),
        .main_en(m1), .batt_en(b1), .batt_on(o1), .ce_out(c1),
        .low_line(l1), .pfo_force_low(p1)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic power_up();
        @(negedge clk);
        below_swdn = 1'b0;
        above_swup = 1'b1;
        tick();
        @(negedge clk);
        below_rst = 1'b0;
        tick();
        chk("R5 main after power-up", main_en, 1'b1);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 u0 batt_en", batt_en, 1'b1);
        chk("R1 u0 main_en", main_en, 1'b0);
        chk("R6 u0 batt_on", batt_on, 1'b1);
        chk("R1 u1 batt_en", b1, 1'b0);
        chk("R1 u1 main_en", m1, 1'b0);
        chk("R6 u1 batt_on", o1, 1'b0);
        chk("R9 u1 pfo", p1, 1'b1);
        chk("R8 u1 low_line", l1, 1'b0);
    endtask

    task automatic t_powerup_band();
        @(negedge clk);
        below_swdn = 1'b0;
        tick();
        chk("R5 band holds battery", batt_en, 1'b1);
        chk("R5 band main off", main_en, 1'b0);
        @(negedge clk);
        above_swup = 1'b1;
        ce_in = 1'b0;
        tick();
        chk("R5 recover main_en", main_en, 1'b1);
        chk("R10 batt_en off", batt_en, 1'b0);
        chk("R6 batt_on low", batt_on, 1'b0);
        chk("R9 pfo released", pfo_force_low, 1'b0);
        chk("R8 low_line under threshold", low_line, 1'b0);
        chk("R7 ce forced high", ce_out, 1'b1);
        @(negedge clk);
        below_rst = 1'b0;
        #1;
        chk("R8 low_line returns", low_line, 1'b1);
        chk("R7 ce follows 0", ce_out, 1'b0);
        ce_in = 1'b1;
        #1;
        chk("R7 ce follows 1", ce_out, 1'b1);
        ce_in = 1'b0;
    endtask

    task automatic t_drop_backup();
        @(negedge clk);
        bkup_req = 1'b1;
        below_rst = 1'b1;
        #1;
        chk("R7 ce forced on drop", ce_out, 1'b1);
        chk("R8 low_line on drop", low_line, 1'b0);
        tick();
        @(negedge clk);
        bkup_req = 1'b0;
        above_swup = 1'b0;
        tick();
        chk("R5 band keeps main", main_en, 1'b1);
        @(negedge clk);
        below_swdn = 1'b1;
        tick();
        chk("R3 batt_en", batt_en, 1'b1);
        chk("R3 main_en", main_en, 1'b0);
        chk("R2 late request ignored batt_on", batt_on, 1'b1);
        chk("R9 pfo forced", pfo_force_low, 1'b1);
    endtask

    task automatic t_drop_save();
        power_up();
        @(negedge clk);
        bkup_req = 1'b0;
        below_rst = 1'b1;
        tick();
        @(negedge clk);
        bkup_req = 1'b1;
        above_swup = 1'b0;
        below_swdn = 1'b1;
        tick();
        chk("R4 main_en off", main_en, 1'b0);
        chk("R2 late request ignored batt_en", batt_en, 1'b0);
        chk("R6 batt_on low in save", batt_on, 1'b0);
        chk("R9 pfo forced in save", pfo_force_low, 1'b1);
        chk("R8 low_line in save", low_line, 1'b0);
        @(negedge clk);
        below_swdn = 1'b0;
        tick();
        chk("R5 save holds in band", main_en, 1'b0);
    endtask

    task automatic t_same_cycle(input logic req);
        power_up();
        @(negedge clk);
        bkup_req = req;
        below_rst = 1'b1;
        above_swup = 1'b0;
        below_swdn = 1'b1;
        tick();
        chk("R2 same-cycle capture batt_en", batt_en, req);
        chk("R4 same-cycle main_en", main_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_powerup_band();
        t_drop_backup();
        t_drop_save();
        t_same_cycle(1'b0);
        t_same_cycle(1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule